// File: doc/BRIEF.md
# Incrementing Block Copy Engine

This engine moves a run of bytes from one place in a 16-bit byte address space to another. It uses a single-port, 8-bit synchronous memory bus. A one-cycle start pulse supplies a source address, a destination address and a byte count. The engine then works through the bytes one at a time: a read request at the current source address, then a write of that byte to the current destination address. After each write it steps both addresses up by one and counts the byte off.

The copy is strictly sequential, and each byte is written before the next one is read. A forward-overlapping copy therefore behaves as a pattern fill. For example, with a zero placed at address A, a copy from A to A+1 of length L zeroes the whole span from A to A+L. The block has a busy/done handshake toward its controller. It performs no address translation and raises no interrupt.

Top module: `blk_copy_engine`

## Requirements
- R1: While reset (rst_n low) is applied, and on leaving it, busy, done and mem_req are all 0.
- R2: A start pulse seen while busy is 0 loads src_in, dst_in and len_in. In the next cycle the engine issues a read request: mem_req=1, mem_we=0, mem_addr equal to the loaded source.
- R3: Every read request is followed in the very next cycle by a write request (mem_req=1, mem_we=1). Its mem_wdata is the byte the memory returns on mem_rdata, one clock after the read request.
- R4: The k-th read of a transfer (k counted from 0) uses source+k, and the k-th write uses destination+k. Both are taken modulo 65536, so 0xFFFF is followed by 0x0000.
- R5: A transfer of length len_in performs exactly len_in reads and len_in writes. A len_in of 0 performs 65536 of each.
- R6: busy is 1 from the cycle after the accepted start through the cycle of the final write. done is 1 for exactly one cycle, the cycle right after the final write, and busy is 0 in that cycle.
- R7: A start pulse that arrives while busy is 1 has no effect: the running transfer keeps its addresses and count.
- R8: Each write completes before the following read. A forward-overlapping copy therefore re-reads bytes it has just written. With a zero stored at 0x2000, copying from 0x2000 to 0x2001 with length 0x1FFF leaves 0x2000 through 0x3FFF all zero.
- R9: While busy is 0, no bus request is made (mem_req is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle command to begin a transfer |
| src_in | input | 16 | First source byte address |
| dst_in | input | 16 | First destination byte address |
| len_in | input | 16 | Byte count, 0 meaning 65536 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the final write |
| mem_req | output | 1 | Memory bus request this cycle |
| mem_we | output | 1 | 1 for a write request, 0 for a read request |
| mem_addr | output | 16 | Byte address of the request |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte returned one clock after a read request |

## Verification
A corrupted address register shows on mem_addr at the next request, at most two cycles later, as a break in the plus-one stride. It then leaves a stray byte in memory that a final comparison against a behavioural copy reveals. A counter fault shows as a wrong number of read/write pairs, or as done arriving early or late relative to the last write. A read issued before the preceding write has landed only shows through data: in an overlapping fill, the region would take on the old contents instead of the seeded byte.

// File: rtl/blk_copy_engine.sv
module blk_copy_engine #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [LW-1:0] len_in,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t          st_q;
  logic [AW-1:0] src_q, dst_q;
  logic [LW-1:0] cnt_q;
  logic          done_q;
  logic          last_byte;

  assign last_byte = (cnt_q == LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          src_q <= src_in;
          dst_q <= dst_in;
          cnt_q <= len_in;
          st_q  <= S_RD;
        end
        S_RD: st_q <= S_WR;
        S_WR: begin
          src_q <= src_q + AW'(1);
          dst_q <= dst_q + AW'(1);
          cnt_q <= cnt_q - LW'(1);
          if (last_byte) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st_q <= S_RD;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign done      = done_q;
  assign mem_req   = busy;
  assign mem_we    = (st_q == S_WR);
  assign mem_addr  = mem_we ? dst_q : src_q;
  assign mem_wdata = mem_rdata;
endmodule

// File: rtl/blk_copy_engine_chk.sv
module blk_copy_engine_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] src_in,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  logic rd, wr;
  assign rd = mem_req && !mem_we;
  assign wr = mem_req && mem_we;

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (rd && mem_addr == $past(src_in)));

  p_rd_then_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> wr);

  p_src_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && $past(wr) && $past(rd, 2)) |-> (mem_addr == $past(mem_addr, 2) + AW'(1)));

  p_dst_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && $past(rd) && $past(wr, 2)) |-> (mem_addr == $past(mem_addr, 2) + AW'(1)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(wr)));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

bind blk_copy_engine blk_copy_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .src_in(src_in), .busy(busy),
  .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/blk_copy_engine_test.sv
module blk_copy_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {source, destination, length}
  localparam logic [47:0] VECS [NVEC] = '{
    {16'h0100, 16'h0200, 16'h0010},
    {16'h0300, 16'h0400, 16'h0001},
    {16'hFFFE, 16'h0005, 16'h0004},
    {16'h0040, 16'hFFFD, 16'h0006},
    {16'h0501, 16'h0500, 16'h0008},
    {16'h0600, 16'h0602, 16'h000A}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] src_in = 0, dst_in = 0, len_in = 0;
  logic busy, done, mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] mem  [int];
  logic [7:0] refm [int];
  int checks = 0, errors = 0;

  blk_copy_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_in(src_in), .dst_in(dst_in),
    .len_in(len_in), .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] dflt(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] dut_rd(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : dflt(a);
  endfunction
  function automatic logic [7:0] ref_rd(input logic [15:0] a);
    return refm.exists(int'(a)) ? refm[int'(a)] : dflt(a);
  endfunction

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[int'(mem_addr)] = mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= dut_rd(mem_addr);
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_copy(input logic [15:0] s, input logic [15:0] d,
                          input logic [15:0] l, input bit poke);
    int n, rdc, wrc, cyc, busy_gaps;
    bit addr_ok, last_we, mem_ok;
    logic [15:0] ms, md;
    n = (l == 0) ? 65536 : int'(l);
    ms = s; md = d;
    for (int k = 0; k < n; k++) begin
      refm[int'(md)] = ref_rd(ms);
      ms++; md++;
    end
    @(negedge clk);
    src_in = s; dst_in = d; len_in = l; start = 1;
    @(negedge clk);
    start = 0;
    chk("R2 first read request", {mem_req, mem_we, mem_addr}, {1'b1, 1'b0, s});
    rdc = 0; wrc = 0; cyc = 0; busy_gaps = 0; addr_ok = 1; last_we = 0;
    while (!done && cyc < 2*n + 10) begin
      if (mem_req && !mem_we) begin
        if (mem_addr != s + 16'(rdc)) addr_ok = 0;
        rdc++;
      end
      if (mem_req && mem_we) begin
        if (mem_addr != d + 16'(wrc)) addr_ok = 0;
        wrc++;
      end
      if (!busy) busy_gaps++;
      last_we = mem_req && mem_we;
      if (poke && cyc == 2) begin
        start = 1; src_in = ~s; dst_in = ~d; len_in = 16'h0001;
      end else start = 0;
      @(negedge clk);
      cyc++;
    end
    start = 0;
    chk("R6 done reached", done, 1);
    chk("R6 done follows final write", last_we, 1);
    chk("R6 busy low with done", busy, 0);
    chk("R6 busy held through transfer", busy_gaps, 0);
    chk(poke ? "R7 read count with ignored start" : "R5 read count", rdc, n);
    chk(poke ? "R7 write count with ignored start" : "R5 write count", wrc, n);
    chk("R4 address strides", addr_ok, 1);
    @(negedge clk);
    chk("R6 done single cycle", done, 0);
    chk("R9 idle bus quiet", mem_req, 0);
    mem_ok = (mem.num() == refm.num());
    foreach (refm[k]) if (!mem.exists(k) || mem[k] != refm[k]) mem_ok = 0;
    chk(poke ? "R7 memory vs model" : "R3 R8 memory vs model", mem_ok, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {busy, done, mem_req}, 3'b000);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset release", {busy, done, mem_req}, 3'b000);

    for (int i = 0; i < NVEC; i++) begin
      mem.delete(); refm.delete();
      run_copy(VECS[i][47:32], VECS[i][31:16], VECS[i][15:0], 1'b0);
    end

    // R8 overlapping fill
    mem.delete(); refm.delete();
    mem[32'h2000] = 8'h00; refm[32'h2000] = 8'h00;
    run_copy(16'h2000, 16'h2001, 16'h1FFF, 1'b0);
    begin
      int bad = 0;
      for (int a = 16'h2000; a <= 16'h3FFF; a++) if (dut_rd(16'(a)) != 8'h00) bad++;
      chk("R8 fill region zero", bad, 0);
    end

    // R7 start while busy ignored
    mem.delete(); refm.delete();
    run_copy(16'h0700, 16'h0800, 16'h0005, 1'b1);

    // R5 length zero means 65536
    mem.delete(); refm.delete();
    run_copy(16'h1000, 16'h9000, 16'h0000, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule